// File: doc/BRIEF.md
# Quad-I/O Flash Identification Responder

This block is the target-side front end of a serial flash operating with all four data lines active. It watches chip select, serial clock and four data lines with its own system clock, takes in an 8-bit command one nibble per serial clock, and replies to two commands. One returns a fixed three-byte identity word. The other returns bytes from a small, computed parameter table, addressed by a 24-bit address.

Every command, address and data transfer moves four bits per serial clock. The only exception is the wait between the address and the parameter data, which always lasts eight serial clocks. A busy input, raised while the surrounding device is programming or erasing, keeps a command from being decoded. Raising chip select ends any transfer at once and releases the data lines.

Top module: `qid_responder`

## Requirements
- R1: After chip select goes low, the command byte is taken on two rising serial clock edges: the upper nibble first, with bit 7 on DQ3.
- R2: Command AFh returns six nibbles: 20h, then BAh, then 17h, each byte upper nibble first. Further clocks repeat the six-nibble sequence from 20h.
- R3: A data nibble changes only after a falling serial clock edge and holds through the following high phase, with bit 7 (or bit 3) of the byte on DQ3.
- R4: Command 5Ah takes six address nibbles, most significant first. After the wait, it returns table bytes starting at the low eight address bits, each byte upper nibble first.
- R5: The parameter read waits exactly eight serial clocks after the last address nibble, with the data lines released during the wait.
- R6: The table pointer advances after each byte and wraps from FFh to 00h while chip select stays low.
- R7: Table bytes 0 to 3 are 53h, 46h, 44h, 50h. Any other index k holds k XOR 5Ah.
- R8: Raising chip select releases the data lines and returns dq_o to zero within a few system clocks. The next selection starts again with a new command.
- R9: If busy_i is high when the second command nibble arrives, the command is not decoded, and the lines stay released until chip select goes high.
- R10: An unknown command is ignored. The lines stay released, and later nibbles in the same selection are not taken as a command.
- R11: dq_oe_o is high only in a data phase, and dq_o is zero whenever dq_oe_o is low.
- R12: After reset, dq_oe_o and dq_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| dq_i | input | 4 | Data lines as seen from the pins |
| busy_i | input | 1 | High while a program or erase cycle runs |
| dq_o | output | 4 | Nibble driven onto the data lines |
| dq_oe_o | output | 1 | Output enable for the data lines |

## Verification
The identity command is run across more than six data clocks, which shows whether the nibble order and the wrap back to the first byte are right. Parameter reads start at index 0, at 10h and at FEh, which separates the fixed signature bytes, the computed bytes and the wrap from FFh to 00h. Each dummy clock is checked for released lines, so a wait shorter than eight clocks is caught. An aborted read, a reversed command byte, an unknown command and a busy-blocked command each show whether the lines stay released and whether the next selection starts clean.

// File: rtl/qid_pkg.sv
package qid_pkg;
  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_ID,
    ST_TBL,
    ST_IGN
  } qid_state_e;

  localparam logic [7:0] OPC_RDID = 8'hAF;
  localparam logic [7:0] OPC_DISC = 8'h5A;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned ADDR_NIB = ADDR_W / 4;
endpackage

// File: rtl/qid_sync.sv
module qid_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qid_edge.sv
module qid_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= s_i;
  end

  assign rise_o = s_i & ~prev_q;
  assign fall_o = ~s_i & prev_q;
endmodule

// File: rtl/qid_table.sv
module qid_table #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    data_o
);
  localparam int unsigned DEPTH = 2 ** AW;
  localparam logic [31:0] SIG = 32'h5346_4450;

  logic [7:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    if (i < 4) begin : g_sig
      assign rom[i] = SIG[31-8*i -: 8];
    end else begin : g_calc
      assign rom[i] = 8'(i) ^ 8'h5A;
    end
  end

  assign data_o = rom[addr_i];
endmodule

// File: rtl/qid_ctrl.sv
module qid_ctrl
  import qid_pkg::*;
#(
  parameter logic [23:0] ID_WORD = 24'h20BA17,
  parameter int unsigned TBL_AW = 8,
  parameter int unsigned DUMMY_CLKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [3:0]        dq_s_i,
  input  logic              busy_i,
  input  logic [7:0]        tbl_byte_i,
  output logic [TBL_AW-1:0] tbl_addr_o,
  output logic [3:0]        dq_o,
  output logic              oe_o
);
  localparam int unsigned CNT_MAX = (ADDR_NIB > DUMMY_CLKS) ? ADDR_NIB : DUMMY_CLKS;
  localparam int unsigned CNT_W = $clog2(CNT_MAX) + 1;

  qid_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        opc_hi_q;
  logic [TBL_AW-1:0] addr_q;
  logic [23:0]       id_sh_q;
  logic              nib_lo_q;
  logic [3:0]        dq_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OPC;
      cnt_q    <= '0;
      opc_hi_q <= '0;
      addr_q   <= '0;
      id_sh_q  <= '0;
      nib_lo_q <= 1'b0;
      dq_q     <= '0;
      oe_q     <= 1'b0;
    end else if (cs_s_i) begin
      state_q  <= ST_OPC;
      cnt_q    <= '0;
      nib_lo_q <= 1'b0;
      dq_q     <= '0;
      oe_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_OPC: if (rise_i) begin
          if (cnt_q == '0) begin
            opc_hi_q <= dq_s_i;
            cnt_q    <= CNT_W'(1);
          end else begin
            cnt_q <= '0;
            if (busy_i) state_q <= ST_IGN;
            else if ({opc_hi_q, dq_s_i} == OPC_RDID) begin
              state_q <= ST_ID;
              id_sh_q <= ID_WORD;
            end else if ({opc_hi_q, dq_s_i} == OPC_DISC) state_q <= ST_ADDR;
            else state_q <= ST_IGN;
          end
        end
        ST_ADDR: if (rise_i) begin
          addr_q <= TBL_AW'({addr_q, dq_s_i});
          if (cnt_q == CNT_W'(ADDR_NIB - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_DUMMY;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DUMMY: if (rise_i) begin
          if (cnt_q == CNT_W'(DUMMY_CLKS - 1)) begin
            cnt_q    <= '0;
            nib_lo_q <= 1'b0;
            state_q  <= ST_TBL;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_ID: if (fall_i) begin
          oe_q    <= 1'b1;
          dq_q    <= id_sh_q[23:20];
          id_sh_q <= {id_sh_q[19:0], id_sh_q[23:20]};
        end
        ST_TBL: if (fall_i) begin
          oe_q     <= 1'b1;
          nib_lo_q <= ~nib_lo_q;
          if (!nib_lo_q) dq_q <= tbl_byte_i[7:4];
          else begin
            dq_q   <= tbl_byte_i[3:0];
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_IGN: ;
        default: state_q <= ST_OPC;
      endcase
    end
  end

  assign tbl_addr_o = addr_q;
  assign dq_o = dq_q;
  assign oe_o = oe_q;

  // R11: enable confined to data states, lines quiet otherwise
  p_oe_in_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state_q == ST_ID || state_q == ST_TBL));
  p_quiet_when_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> dq_q == 4'h0);
  // R8: deselect releases the lines
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !oe_q && dq_q == 4'h0);
  // R3: nibble moves only after a falling edge
  p_fall_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s_i && !$past(cs_s_i) && !$stable(dq_q)) |-> $past(fall_i));
  // R5: data phase entered only from the dummy wait on a rising edge
  p_dummy_then_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_TBL) |-> ($past(state_q) == ST_DUMMY && $past(rise_i)));
  // R9: busy at decode blocks the command
  p_busy_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s_i && state_q == ST_OPC && rise_i && cnt_q != '0 && busy_i) |=> state_q == ST_IGN);
  // R10: ignored selection never drives
  p_ignore_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IGN |-> !oe_q);
  // R6: pointer wraps after the last byte
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s_i && state_q == ST_TBL && fall_i && nib_lo_q && addr_q == '1) |=> addr_q == '0);
endmodule

// File: rtl/qid_responder.sv
module qid_responder #(
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'hBA,
  parameter logic [7:0] CAP_ID = 8'h17,
  parameter int unsigned TBL_AW = 8,
  parameter int unsigned DUMMY_CLKS = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic [3:0] dq_i,
  input  logic       busy_i,
  output logic [3:0] dq_o,
  output logic       dq_oe_o
);
  localparam int unsigned SW = 6;
  localparam logic [SW-1:0] SYNC_RST = 6'b10_0000;

  logic [SW-1:0]     pins_s;
  logic              cs_s, sck_s, sck_rise, sck_fall;
  logic [3:0]        dq_s;
  logic [TBL_AW-1:0] tbl_addr;
  logic [7:0]        tbl_byte;

  qid_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, dq_i}),
    .q_o   (pins_s)
  );

  assign cs_s  = pins_s[5];
  assign sck_s = pins_s[4];
  assign dq_s  = pins_s[3:0];

  qid_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (sck_s),
    .rise_o(sck_rise),
    .fall_o(sck_fall)
  );

  qid_table #(.AW(TBL_AW)) u_table (
    .addr_i(tbl_addr),
    .data_o(tbl_byte)
  );

  qid_ctrl #(
    .ID_WORD   ({MFR_ID, DEV_ID, CAP_ID}),
    .TBL_AW    (TBL_AW),
    .DUMMY_CLKS(DUMMY_CLKS)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_s),
    .rise_i    (sck_rise),
    .fall_i    (sck_fall),
    .dq_s_i    (dq_s),
    .busy_i    (busy_i),
    .tbl_byte_i(tbl_byte),
    .tbl_addr_o(tbl_addr),
    .dq_o      (dq_o),
    .oe_o      (dq_oe_o)
  );
endmodule

// File: tb/sim_qid_responder.sv
module sim_qid_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  typedef struct {
    logic       oe;
    logic [3:0] nib;
    int         req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_r = 1'b1, sck_r = 1'b0, busy_r = 1'b0;
  logic [3:0] dq_r = 4'h0;
  logic [3:0] dq_o;
  logic dq_oe;

  int total = 0, bad = 0;
  bit done = 1'b0;
  exp_t sb[$];
  exp_t cur;
  bit have = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qid_responder u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_ni  (cs_r),
    .sck_i  (sck_r),
    .dq_i   (dq_r),
    .busy_i (busy_r),
    .dq_o   (dq_o),
    .dq_oe_o(dq_oe)
  );

  task automatic check(input bit ok, input int req, input logic [4:0] act, input logic [4:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual oe/dq=%h expected oe/dq=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] ref_tbl(input logic [7:0] k);
    case (k)
      8'd0: return 8'h53;
      8'd1: return 8'h46;
      8'd2: return 8'h44;
      8'd3: return 8'h50;
      default: return k ^ 8'h5A;
    endcase
  endfunction

  // monitor: pop at the master's sampling edge
  always @(posedge sck_r) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      have = 1'b1;
      check({dq_oe, dq_o} == {cur.oe, cur.oe ? cur.nib : 4'h0}, cur.req,
            {dq_oe, dq_o}, {cur.oe, cur.oe ? cur.nib : 4'h0});
    end else have = 1'b0;
  end

  // R3: value still held at the end of the high phase
  always @(negedge sck_r) begin
    if (have && cur.oe)
      check({dq_oe, dq_o} == {1'b1, cur.nib}, 3, {dq_oe, dq_o}, {1'b1, cur.nib});
  end

  task automatic sck_cycle(input logic [3:0] nib);
    dq_r = nib;
    repeat (HALF) @(negedge clk);
    sck_r = 1'b1;
    repeat (HALF) @(negedge clk);
    sck_r = 1'b0;
  endtask

  task automatic expect_cycle(input logic oe, input logic [3:0] nib, input int req);
    exp_t e;
    e.oe = oe; e.nib = nib; e.req = req;
    sb.push_back(e);
    sck_cycle(4'h0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    sck_cycle(b[7:4]);
    sck_cycle(b[3:0]);
  endtask

  task automatic select();
    @(negedge clk) cs_r = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic deselect();
    repeat (2) @(negedge clk);
    cs_r = 1'b1;
    repeat (6) @(negedge clk);
    // R8: lines released after deselect
    check({dq_oe, dq_o} == 5'h00, 8, {dq_oe, dq_o}, 5'h00);
  endtask

  task automatic expect_id(input int nibs);
    logic [23:0] w = 24'h20BA17;
    for (int i = 0; i < nibs; i++) begin
      expect_cycle(1'b1, w[23:20], 2);  // R2
      w = {w[19:0], w[23:20]};
    end
  endtask

  task automatic rd_disc(input logic [23:0] a, input int nbytes);
    select();
    send_byte(8'h5A);  // R4
    for (int i = 5; i >= 0; i--) sck_cycle(a[4*i +: 4]);
    for (int i = 0; i < 8; i++) expect_cycle(1'b0, 4'h0, 5);  // R5
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = ref_tbl(a[7:0] + 8'(i));  // R6 R7
      expect_cycle(1'b1, b[7:4], 4);
      expect_cycle(1'b1, b[3:0], 7);
    end
    deselect();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset values
    check({dq_oe, dq_o} == 5'h00, 12, {dq_oe, dq_o}, 5'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2: identity read with wrap
    select(); send_byte(8'hAF); expect_id(12); deselect();

    // R8: abort mid-data, then a fresh read restarts
    select(); send_byte(8'hAF); expect_id(3); deselect();
    select(); send_byte(8'hAF); expect_id(2); deselect();

    // R4 R5 R7: signature bytes into computed bytes
    rd_disc(24'h000000, 5);
    // R7: computed region
    rd_disc(24'h000010, 2);
    // R6: wrap FFh to 00h, upper address bits ignored
    rd_disc(24'hABCDFE, 3);

    // R1: reversed nibble order is not the identity command
    select(); send_byte(8'hFA);
    for (int i = 0; i < 4; i++) expect_cycle(1'b0, 4'h0, 1);
    deselect();

    // R10: unknown command, then later opcode in same selection
    select(); send_byte(8'h9F);
    for (int i = 0; i < 4; i++) expect_cycle(1'b0, 4'h0, 10);
    send_byte(8'hAF);
    for (int i = 0; i < 4; i++) expect_cycle(1'b0, 4'h0, 10);
    deselect();

    // R9: busy blocks decode; cleared busy works on next selection
    select(); busy_r = 1'b1; send_byte(8'hAF); busy_r = 1'b0;
    for (int i = 0; i < 6; i++) expect_cycle(1'b0, 4'h0, 9);
    deselect();
    select(); send_byte(8'hAF); expect_id(2); deselect();

    // R11: nothing left unmatched in the scoreboard
    check(sb.size() == 0, 11, 5'(sb.size()), 5'h00);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule